// File: doc/BRIEF.md
# Switch Control and Test Register File

This block is the control and status register bank of a network switch device. A host-side bus bridge, which is not part of this block, reaches it through a simple 32-bit register port. The port carries a byte offset, a write strobe with write data, and a read strobe. The read data appears one cycle after the read strobe.

The bank has four kinds of register:
- **Guard window.** The first sixteen bytes are a window that catches stray accesses.
- **Test registers.** A 32-bit and a 64-bit register return double the value last written to them. A third test register raises a one-cycle interrupt request on any vector software names.
- **Switch-wide state.** This covers a 64-bit port enable bitmap, a read-only link status bitmap fed from the port logic, a read-only physical port count, and a read-only 64-bit switch identifier.
- **Control register.** It is write-only, and writing it issues a device reset request.

Software accesses 64-bit registers as two 32-bit halves, lower half first. A 64-bit register that software can write takes its new value only when the upper half is written.

Top module: `swctl_regfile`

## Requirements
- R1: A read from any offset 0x000 to 0x00F returns 0xDEADBABE. A write in that range changes no register.
- R2: A read from an offset that holds no register returns 0. A write to such an offset changes no register.
- R3: After a write of V to offset 0x010, a read of 0x010 returns (2*V) mod 2^32.
- R4: The 64-bit test register uses offset 0x018 for the low half and 0x01C for the high half. A write to 0x018 only stages the low half. A write to 0x01C commits {high, staged low} as V. After the commit, the two offsets read as the low and high halves of (2*V) mod 2^64. Reads made before the commit return the earlier value.
- R5: A write of V to offset 0x020 sets irq_valid high for exactly one cycle, in the cycle after the write, with irq_vector = V[VEC_W-1:0]. A read of 0x020 returns the last vector written.
- R6: The port enable bitmap uses offset 0x318 for bits 31:0 and 0x31C for bits 63:32. It resets to 0. It is committed on the upper-half write, in the same way as R4. Bits 0 and 63 always stay 0. The committed value drives port_en.
- R7: A read of offset 0x310 returns link_up[31:0] with bit 0 forced to 0. A read of 0x314 returns link_up[63:32] with bit 31 forced to 0.
- R8: A write to offset 0x300 with bit 0 set pulses dev_reset_req high for exactly one cycle, in the cycle after the write. A write with bit 0 clear gives no pulse. A read of 0x300 returns 0.
- R9: Offset 0x304 reads PHYS_COUNT. Offsets 0x320 and 0x324 read the low and high halves of SWITCH_ID.
- R10: reg_rdata is registered. It takes the value of the addressed register in the cycle after reg_rd and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Byte offset of the access (bits 1:0 ignored) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| link_up | input | 64 | Per-port link state from the port logic |
| port_en | output | 64 | Committed port enable bitmap |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | VEC_W | Vector of the interrupt request |
| dev_reset_req | output | 1 | One-cycle device reset request |

## Verification
The assertions assume that reg_rd and reg_wr are never both high in the same cycle. They also assume that link_up is stable in the cycle after a read of the link status offsets, because the link check compares the read data with link_up as it was in the read cycle.

The stimulus meets both assumptions. It issues every access on its own, from the falling clock edge, and it changes link_up only while the bus is idle. Each 64-bit write sequence always puts the low half before the high half. One extra case writes the low half and then reads the register before writing the high half, to show that the staged half has not yet taken effect.

// File: rtl/swctl_regfile.sv
module swctl_regfile #(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned PHYS_COUNT = 62,
  parameter logic [63:0] SWITCH_ID  = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata,
  input  logic [63:0]       link_up,
  output logic [63:0]       port_en,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              dev_reset_req
);

  localparam logic [31:0] GUARD_WORD = 32'hDEAD_BABE;
  localparam logic [ADDR_W-1:0] A_T32   = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] A_T64L  = ADDR_W'('h018);
  localparam logic [ADDR_W-1:0] A_T64H  = ADDR_W'('h01C);
  localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'('h020);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'('h300);
  localparam logic [ADDR_W-1:0] A_PCNT  = ADDR_W'('h304);
  localparam logic [ADDR_W-1:0] A_LNKL  = ADDR_W'('h310);
  localparam logic [ADDR_W-1:0] A_LNKH  = ADDR_W'('h314);
  localparam logic [ADDR_W-1:0] A_ENL   = ADDR_W'('h318);
  localparam logic [ADDR_W-1:0] A_ENH   = ADDR_W'('h31C);
  localparam logic [ADDR_W-1:0] A_IDL   = ADDR_W'('h320);
  localparam logic [ADDR_W-1:0] A_IDH   = ADDR_W'('h324);
  localparam logic [63:0] EDGE_MASK = 64'h7FFF_FFFF_FFFF_FFFE;

  logic [ADDR_W-1:0] word_a;
  logic              in_guard;
  logic [31:0]       t32_q;
  logic [63:0]       t64_q;
  logic [31:0]       t64_stage;
  logic [31:0]       en_stage;
  logic [VEC_W-1:0]  vec_q;
  logic [63:0]       t64_dbl;
  logic [63:0]       link_vis;
  logic [31:0]       rd_mux;

  assign word_a   = {reg_addr[ADDR_W-1:2], 2'b00};
  assign in_guard = (word_a[ADDR_W-1:4] == '0);
  assign t64_dbl  = t64_q << 1;
  assign link_vis = link_up & EDGE_MASK;
  assign irq_vector = vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t32_q         <= '0;
      t64_q         <= '0;
      t64_stage     <= '0;
      en_stage      <= '0;
      port_en       <= '0;
      vec_q         <= '0;
      irq_valid     <= 1'b0;
      dev_reset_req <= 1'b0;
    end else begin
      irq_valid     <= 1'b0;
      dev_reset_req <= 1'b0;
      if (reg_wr && !in_guard) begin
        case (word_a)
          A_T32:  t32_q     <= reg_wdata;
          A_T64L: t64_stage <= reg_wdata;
          A_T64H: t64_q     <= {reg_wdata, t64_stage};
          A_IRQ: begin
            vec_q     <= reg_wdata[VEC_W-1:0];
            irq_valid <= 1'b1;
          end
          A_CTRL: dev_reset_req <= reg_wdata[0];
          A_ENL:  en_stage <= reg_wdata;
          A_ENH:  port_en  <= {reg_wdata, en_stage} & EDGE_MASK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_guard) rd_mux = GUARD_WORD;
    else begin
      case (word_a)
        A_T32:  rd_mux = t32_q << 1;
        A_T64L: rd_mux = t64_dbl[31:0];
        A_T64H: rd_mux = t64_dbl[63:32];
        A_IRQ:  rd_mux = 32'(vec_q);
        A_PCNT: rd_mux = 32'(PHYS_COUNT);
        A_LNKL: rd_mux = link_vis[31:0];
        A_LNKH: rd_mux = link_vis[63:32];
        A_ENL:  rd_mux = port_en[31:0];
        A_ENH:  rd_mux = port_en[63:32];
        A_IDL:  rd_mux = SWITCH_ID[31:0];
        A_IDH:  rd_mux = SWITCH_ID[63:32];
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

endmodule

// File: rtl/swctl_regfile_chk.sv
module swctl_regfile_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic              reg_rd,
  input logic [31:0]       reg_rdata,
  input logic [63:0]       link_up,
  input logic [63:0]       port_en,
  input logic              irq_valid,
  input logic [VEC_W-1:0]  irq_vector,
  input logic              dev_reset_req
);

  logic [ADDR_W-1:0] wa;
  assign wa = {reg_addr[ADDR_W-1:2], 2'b00};

  assert_guard_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && wa < ADDR_W'('h010)) |=> (reg_rdata == 32'hDEAD_BABE));

  assert_irq_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && wa == ADDR_W'('h020)) |=>
      (irq_valid && irq_vector == $past(reg_wdata[VEC_W-1:0])));

  assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !$past(reg_wr && wa == ADDR_W'('h020))) |-> 1'b0);

  assert_enable_edges_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (wa == ADDR_W'('h318) || wa == ADDR_W'('h31C))) |=>
      (reg_rdata == ($past(wa) == ADDR_W'('h318) ? $past(port_en[31:0]) : $past(port_en[63:32]))
       && !port_en[0] && !port_en[63]));

  assert_link_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && wa == ADDR_W'('h310)) |=>
      (reg_rdata == ($past(link_up[31:0]) & 32'hFFFF_FFFE)));

  assert_reset_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset_req |-> $past(reg_wr && wa == ADDR_W'('h300) && reg_wdata[0]));

  assert_ctrl_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && wa == ADDR_W'('h300)) |=> (reg_rdata == 32'h0));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rd) |=> $stable(reg_rdata));

endmodule

bind swctl_regfile swctl_regfile_chk #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/test_swctl_regfile.sv
`timescale 1ns/100ps
module test_swctl_regfile;
  localparam int unsigned AW = 13;
  localparam logic [63:0] ID = 64'hA5A5_0000_1234_5678;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] link_up = '0;
  logic [63:0] port_en;
  logic irq_valid, dev_reset_req;
  logic [7:0] irq_vector;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  swctl_regfile #(.ADDR_W(AW), .VEC_W(8), .PHYS_COUNT(62), .SWITCH_ID(ID)) i_swctl_regfile (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .link_up(link_up), .port_en(port_en),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .dev_reset_req(dev_reset_req));

  // {is_write, req, addr, wdata, expected}
  localparam int NV = 31;
  localparam logic [84:0] VEC [NV] = '{
    {1'b1, 4'd3,  16'h010, 32'h1234_5678, 32'h0},
    {1'b0, 4'd3,  16'h010, 32'h0,         32'h2468_ACF0},
    {1'b1, 4'd3,  16'h010, 32'h8000_0001, 32'h0},
    {1'b0, 4'd3,  16'h010, 32'h0,         32'h0000_0002},
    {1'b0, 4'd1,  16'h000, 32'h0,         32'hDEAD_BABE},
    {1'b1, 4'd1,  16'h004, 32'h1111_1111, 32'h0},
    {1'b0, 4'd1,  16'h004, 32'h0,         32'hDEAD_BABE},
    {1'b0, 4'd1,  16'h00C, 32'h0,         32'hDEAD_BABE},
    {1'b0, 4'd3,  16'h010, 32'h0,         32'h0000_0002},
    {1'b1, 4'd2,  16'h040, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 4'd2,  16'h040, 32'h0,         32'h0},
    {1'b0, 4'd2,  16'h200, 32'h0,         32'h0},
    {1'b1, 4'd4,  16'h018, 32'h0000_0001, 32'h0},
    {1'b0, 4'd4,  16'h018, 32'h0,         32'h0},
    {1'b1, 4'd4,  16'h01C, 32'h8000_0000, 32'h0},
    {1'b0, 4'd4,  16'h018, 32'h0,         32'h0000_0002},
    {1'b0, 4'd4,  16'h01C, 32'h0,         32'h0},
    {1'b1, 4'd4,  16'h018, 32'h8000_0000, 32'h0},
    {1'b1, 4'd4,  16'h01C, 32'h0000_0001, 32'h0},
    {1'b0, 4'd4,  16'h018, 32'h0,         32'h0},
    {1'b0, 4'd4,  16'h01C, 32'h0,         32'h0000_0003},
    {1'b1, 4'd6,  16'h318, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 4'd6,  16'h318, 32'h0,         32'h0},
    {1'b1, 4'd6,  16'h31C, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 4'd6,  16'h318, 32'h0,         32'hFFFF_FFFE},
    {1'b0, 4'd6,  16'h31C, 32'h0,         32'h7FFF_FFFF},
    {1'b0, 4'd8,  16'h300, 32'h0,         32'h0},
    {1'b0, 4'd9,  16'h304, 32'h0,         32'd62},
    {1'b0, 4'd9,  16'h320, 32'h0,         32'h1234_5678},
    {1'b0, 4'd9,  16'h324, 32'h0,         32'hA5A5_0000},
    {1'b0, 4'd7,  16'h310, 32'h0,         32'hFFFF_FFFE}
  };

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
      4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
      4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a[AW-1:0]; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a[AW-1:0]; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R6 reset port_en", port_en, 64'h0);
    check("R5 reset irq_valid", {63'h0, irq_valid}, 64'h0);
    check("R10 reset rdata", {32'h0, reg_rdata}, 64'h0);
    rst_n = 1'b1;
    link_up = 64'hFFFF_FFFF_FFFF_FFFF;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][84]) wr(VEC[i][79:64], VEC[i][63:32]);
      else begin
        rd(VEC[i][79:64], d);
        check(tag(VEC[i][83:80]), {32'h0, d}, {32'h0, VEC[i][31:0]});
      end
    end
    check("R6 port_en output", port_en, 64'h7FFF_FFFF_FFFF_FFFE);
    rd(16'h314, d);
    check("R7 link high", {32'h0, d}, 64'h7FFF_FFFF);
    @(negedge clk); link_up = 64'h0000_0000_0000_00A5;
    rd(16'h310, d);
    check("R7 link pattern", {32'h0, d}, 64'hA4);

    wr(16'h020, 32'h0000_0105);
    check("R5 irq pulse", {55'h0, irq_valid, irq_vector}, {55'h0, 1'b1, 8'h05});
    @(negedge clk);
    check("R5 irq one cycle", {63'h0, irq_valid}, 64'h0);
    rd(16'h020, d);
    check("R5 vector readback", {32'h0, d}, 64'h05);

    wr(16'h300, 32'h1);
    check("R8 reset pulse", {63'h0, dev_reset_req}, 64'h1);
    @(negedge clk);
    check("R8 pulse ends", {63'h0, dev_reset_req}, 64'h0);
    wr(16'h300, 32'hFFFF_FFFE);
    check("R8 bit0 clear no pulse", {63'h0, dev_reset_req}, 64'h0);

    rd(16'h304, d);
    wr(16'h010, 32'h5);
    check("R10 rdata holds", {32'h0, reg_rdata}, 64'd62);

    wr(16'h318, 32'h0000_0001);
    wr(16'h31C, 32'h8000_0000);
    check("R6 edge bits dropped", port_en, 64'h0);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R6 reset clears port_en", port_en, 64'h0);
    rst_n = 1'b1;
    rd(16'h010, d);
    check("R3 reset clears test", {32'h0, d}, 64'h0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule